// File: doc/BRIEF.md
# Configuration Memory Controller with Security Lock

This block fronts the storage that holds a logic array's connection map and its output-cell configuration bits. A host issues one of four commands through a command/address/data port: clear the whole store, program one row, read one row back, or set a security lock. Each accepted command raises `busy` for one cycle and then pulses `done`. A command that the lock forbids is reported on `err` in the same cycle as `done`.

The store is a set of rows that are `DW` bits wide. A bit at 1 is a closed connection. Clearing the store opens every connection, so every bit goes to 0. Programming can only close connections: the written word is ORed into the row. Reopening a connection takes a full erase, so the normal flow is erase, then program, then optionally lock.

The lock can be set by its own command, or as the last step of a program command by raising `cmd_lock`. While the lock is set, row reads and row programming are refused. A refused read drives zeros on `rd_data` instead of the stored row. Only the erase command releases the lock, and it clears the whole store in the same operation. Electrical programming time is not modelled: every write completes in one cycle.

Top module: `cfgmem_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy`, `done`, `err` and `secured` are 0, `rd_data` is all zeros, and every row reads back as zero.
- R2: The opcodes on `cmd_op` are 00 erase, 01 program-row, 10 read-row and 11 set-lock. A command is accepted at a rising edge where `cmd_valid` is 1 and `busy` is 0. `busy` is 1 for exactly the following cycle. `done` is then 1 for exactly one cycle with `busy` at 0. `cmd_valid` is ignored while `busy` is 1.
- R3: An erase sets every row to zero and clears `secured`. It never reports `err`.
- R4: A program-row that is allowed ORs `cmd_wdata` into the row at `cmd_addr`. Bits already at 1 stay at 1.
- R5: A read-row that is allowed places the addressed row on `rd_data` in the `done` cycle. `rd_data` keeps that value until the next read-row completes.
- R6: A set-lock command sets `secured` in its `done` cycle and never reports `err`, even when the lock is already set. A program-row with `cmd_lock` at 1 writes the row and also sets `secured`.
- R7: While `secured` is 1, a program-row is refused: `err` is 1 together with `done`, and `secured` stays 1.
- R8: While `secured` is 1, a read-row is refused: `err` is 1 together with `done`, and `rd_data` becomes all zeros.
- R9: `err` is only ever 1 in a `done` cycle. `secured` falls only through an erase or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Opcode: 00 erase, 01 program, 10 read, 11 lock |
| cmd_addr | input | AW | Row address, AW = clog2(ROWS) |
| cmd_wdata | input | DW | Connections to close on program |
| cmd_lock | input | 1 | Set the lock after this program command |
| busy | output | 1 | Command executing |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Command refused, valid with done |
| secured | output | 1 | Security lock state |
| rd_data | output | DW | Row read back, zeros when refused |

## Verification
The assertions assume that the host changes `cmd_op` only while `cmd_valid` is 1 or while no command is in flight. They also assume that the host waits for `done` before it relies on `secured` or `rd_data`. The stimulus drives every input on the falling edge. It issues each command as a single-cycle request and waits through `busy` and `done` before it issues the next one. One directed case deliberately holds `cmd_valid` high through the busy cycle to show that the extra request is dropped.

// File: rtl/cfgmem_pkg.sv
// Package: shared opcode type for the configuration memory controller.
// Assumes: a two-bit opcode field on the command port.
package cfgmem_pkg;
    typedef enum logic [1:0] {
        OP_ERASE = 2'b00,
        OP_PROG  = 2'b01,
        OP_READ  = 2'b10,
        OP_LOCK  = 2'b11
    } cfg_op_e;
endpackage

// File: rtl/cfgmem_seq.sv
// Module: command sequencer. Accepts one command when idle, holds it for
// one execute cycle, and decides from the lock state whether the command
// runs or is refused. It produces busy/done/err and the per-operation strobes.
// Assumes: the inputs are synchronous to clk, and the reset is synchronous active-low.
module cfgmem_seq
    import cfgmem_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    input  logic          cmd_lock,
    input  logic          secured,
    output logic          busy,
    output logic          done,
    output logic          err,
    output cfg_op_e       cap_op,
    output logic [AW-1:0] cap_addr,
    output logic [DW-1:0] cap_wdata,
    output logic          do_erase,
    output logic          do_prog,
    output logic          do_read,
    output logic          rd_clear,
    output logic          do_lock
);
    logic    cap_lock;
    logic    refused;
    logic    accept;

    assign accept = cmd_valid && !busy;

    // Decode the captured command against the current lock state.
    always_comb begin
        refused  = busy && secured && (cap_op == OP_PROG || cap_op == OP_READ);
        do_erase = busy && cap_op == OP_ERASE;
        do_prog  = busy && cap_op == OP_PROG && !secured;
        do_read  = busy && cap_op == OP_READ && !secured;
        rd_clear = busy && cap_op == OP_READ && secured;
        do_lock  = busy && (cap_op == OP_LOCK || (cap_op == OP_PROG && !secured && cap_lock));
    end

    // Handshake state: busy for one cycle after accept, then a done/err pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            busy <= accept;
            done <= busy;
            err  <= refused;
        end
    end

    // Capture the command fields when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_op    <= OP_ERASE;
            cap_addr  <= '0;
            cap_wdata <= '0;
            cap_lock  <= 1'b0;
        end else if (accept) begin
            cap_op    <= cfg_op_e'(cmd_op);
            cap_addr  <= cmd_addr;
            cap_wdata <= cmd_wdata;
            cap_lock  <= cmd_lock;
        end
    end
endmodule

// File: rtl/cfgmem_store.sv
// Module: the row store plus the readback register. Erase clears all rows in
// one cycle; program ORs data into one row; read loads the readback register,
// or clears it on a refused read.
// Assumes: at most one strobe is active per cycle, and ROWS is a power of two.
module cfgmem_store #(
    parameter int ROWS = 16,
    parameter int DW   = 32,
    localparam int AW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_erase,
    input  logic          do_prog,
    input  logic          do_read,
    input  logic          rd_clear,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] row_q [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        // One row: cleared by reset or erase, ORed on a program hit.
        always_ff @(posedge clk) begin
            if (!rst_n || do_erase)
                row_q[r] <= '0;
            else if (do_prog && addr == AW'(r))
                row_q[r] <= row_q[r] | wdata;
        end
    end

    // Readback register: loads on an allowed read, zeroed on a refused one.
    always_ff @(posedge clk) begin
        if (!rst_n || rd_clear)
            rd_data <= '0;
        else if (do_read)
            rd_data <= row_q[addr];
    end
endmodule

// File: rtl/cfgmem_lock.sv
// Module: the security lock bit. Set by a lock strobe, cleared only by erase or reset.
// Assumes: erase and lock strobes are never active together.
module cfgmem_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic do_erase,
    input  logic do_lock,
    output logic secured
);
    // Lock state: erase has priority as the only release path.
    always_ff @(posedge clk) begin
        if (!rst_n || do_erase)
            secured <= 1'b0;
        else if (do_lock)
            secured <= 1'b1;
    end
endmodule

// File: rtl/cfgmem_ctrl.sv
// Module: top of the configuration memory controller. It ties the sequencer,
// the row store and the lock bit together behind a command/address/data port.
// Assumes: a single clock domain and a synchronous active-low reset.
module cfgmem_ctrl
    import cfgmem_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int DW   = 32,
    localparam int AW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    input  logic          cmd_lock,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          secured,
    output logic [DW-1:0] rd_data
);
    cfg_op_e       cap_op;
    logic [AW-1:0] cap_addr;
    logic [DW-1:0] cap_wdata;
    logic          do_erase, do_prog, do_read, rd_clear, do_lock;

    cfgmem_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_lock(cmd_lock), .secured(secured),
        .busy(busy), .done(done), .err(err),
        .cap_op(cap_op), .cap_addr(cap_addr), .cap_wdata(cap_wdata),
        .do_erase(do_erase), .do_prog(do_prog), .do_read(do_read),
        .rd_clear(rd_clear), .do_lock(do_lock)
    );

    cfgmem_store #(.ROWS(ROWS), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .do_erase(do_erase), .do_prog(do_prog), .do_read(do_read),
        .rd_clear(rd_clear), .addr(cap_addr), .wdata(cap_wdata),
        .rd_data(rd_data)
    );

    cfgmem_lock u_lock (
        .clk(clk), .rst_n(rst_n),
        .do_erase(do_erase), .do_lock(do_lock), .secured(secured)
    );
endmodule

// File: rtl/cfgmem_checker.sv
// Module: protocol and lock checks for cfgmem_ctrl, attached by bind.
// Assumes: the host changes cmd_op only with a new request.
module cfgmem_checker
    import cfgmem_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [1:0]    cmd_op,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic          secured,
    input logic [DW-1:0] rd_data,
    input cfg_op_e       cap_op
);
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !busy |=> busy); // R2
    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy && done); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_ERR_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R9
    AST_ERASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cap_op == OP_ERASE |=> !secured && !err); // R3
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && cap_op == OP_READ) |=> $stable(rd_data)); // R5
    AST_LOCK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cap_op == OP_LOCK |=> secured && !err); // R6
    AST_PROG_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cap_op == OP_PROG && secured |=> err && secured); // R7
    AST_READ_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cap_op == OP_READ && secured |=> err && rd_data == '0); // R8
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        secured && !(busy && cap_op == OP_ERASE) |=> secured); // R9
endmodule

bind cfgmem_ctrl cfgmem_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .done(done), .err(err), .secured(secured),
    .rd_data(rd_data), .cap_op(cap_op)
);

// File: tb/sim_cfgmem_ctrl.sv
module sim_cfgmem_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 16;
    localparam int DW   = 32;
    localparam int AW   = $clog2(ROWS);
    localparam int VW   = 2 + AW + DW + 1 + 1 + 1 + 1 + DW;
    localparam int NV   = 18;

    // Vector: op, addr, wdata, lock, exp_err, exp_secured, check_rd, exp_rd
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'b10, 4'd3,  32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 32'h0},         // R1 row zero
        {2'b01, 4'd3,  32'hA5A5_0F0F, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},         // R4
        {2'b10, 4'd3,  32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 32'hA5A5_0F0F}, // R5
        {2'b01, 4'd3,  32'h0000_F0F0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},         // R4
        {2'b10, 4'd3,  32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 32'hA5A5_FFFF}, // R4 OR
        {2'b01, 4'd15, 32'h8000_0001, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},         // R4
        {2'b10, 4'd15, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 32'h8000_0001}, // R5
        {2'b10, 4'd0,  32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 32'h0},         // R5
        {2'b11, 4'd0,  32'h0,         1'b0, 1'b0, 1'b1, 1'b0, 32'h0},         // R6
        {2'b10, 4'd3,  32'h0,         1'b0, 1'b1, 1'b1, 1'b1, 32'h0},         // R8
        {2'b01, 4'd0,  32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0},         // R7
        {2'b11, 4'd0,  32'h0,         1'b0, 1'b0, 1'b1, 1'b0, 32'h0},         // R6 relock
        {2'b00, 4'd0,  32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 32'h0},         // R3
        {2'b10, 4'd3,  32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 32'h0},         // R3
        {2'b10, 4'd15, 32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 32'h0},         // R3
        {2'b01, 4'd5,  32'h1234_5678, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0},         // R6 prog+lock
        {2'b10, 4'd5,  32'h0,         1'b0, 1'b1, 1'b1, 1'b1, 32'h0},         // R8
        {2'b00, 4'd0,  32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 32'h0}          // R3
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          cmd_lock = 1'b0;
    logic          busy, done, err, secured;
    logic [DW-1:0] rd_data;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgmem_ctrl #(.ROWS(ROWS), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_lock(cmd_lock),
        .busy(busy), .done(done), .err(err), .secured(secured), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one command and check the busy cycle and the done cycle.
    task automatic run_cmd(input logic [1:0] op, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input logic lk,
                           input logic exp_err, input logic exp_sec,
                           input logic chk_rd, input logic [DW-1:0] exp_rd);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_lock = lk;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R2 busy", {63'b0, busy}, 64'd1);
        @(negedge clk);
        check("R2 done", {62'b0, busy, done}, 64'd1);
        check("R7/R8 err", {63'b0, err}, {63'b0, exp_err});
        check("R6/R9 secured", {63'b0, secured}, {63'b0, exp_sec});
        if (chk_rd) check("R5/R8 rd_data", {32'b0, rd_data}, {32'b0, exp_rd});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 outputs in reset", {60'b0, busy, done, err, secured}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after reset", {60'b0, busy, done, err, secured}, 64'd0);
        check("R1 rd_data", {32'b0, rd_data}, 64'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            run_cmd(v[VW-1 -: 2], v[VW-3 -: AW], v[VW-3-AW -: DW], v[DW+3],
                    v[DW+2], v[DW+1], v[DW], v[DW-1:0]);
        end

        // R2: done lasts one cycle
        @(negedge clk);
        check("R2 done single", {63'b0, done}, 64'd0);

        // R2: request held during busy is ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = 4'd1; cmd_wdata = 32'h1; cmd_lock = 1'b0;
        @(negedge clk);
        cmd_addr = 4'd2; cmd_wdata = 32'h2;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R2 done after held request", {63'b0, done}, 64'd1);
        @(negedge clk);
        check("R2 no second accept", {63'b0, busy}, 64'd0);
        run_cmd(2'b10, 4'd2, '0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0);
        run_cmd(2'b10, 4'd1, '0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1);

        // R1: reset while secured releases lock and clears readback and store
        run_cmd(2'b11, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears secured", {63'b0, secured}, 64'd0);
        rst_n = 1'b1;
        run_cmd(2'b10, 4'd1, '0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule